// File: doc/BRIEF.md
# Gapped-Clock Serial Octet Transmitter

This block turns a stream of octets into one bit stream on a single serial data line that is paced by an external link clock. The link clock may stop at any moment and stay stopped for any length of time. The block runs on a fast system clock. It brings the link clock into that domain through a synchroniser and watches it for the active edge. A configuration input chooses whether the rising or the falling edge is the active one. The data line moves to the next bit only when an active edge is detected. At every other time, including a stopped clock held low or held high, the line keeps its current bit.

Octets come in through a valid/ready byte port and leave most significant bit first. There are no time slots and no framing: the last bit of one octet is followed directly by the first bit of the next. The next octet is taken only on the active edge that follows the last bit of the current one. If nothing is offered at that moment, the block sends a one for that bit period and raises an underrun flag. It tries again on the next active edge.

Top module: `gapclk_ser_tx`

## Requirements
- R1: Each accepted octet appears on `ser_out` one bit per active link-clock edge, bit 7 first and bit 0 last.
- R2: Consecutive octets form a continuous stream: when a byte is waiting, its bit 7 goes out on the active edge right after the previous octet's bit 0, with no filler bit between them.
- R3: With `cfg_fall_edge` = 0 only rising link-clock edges move `ser_out`; with `cfg_fall_edge` = 1 only falling edges do. An edge of the other direction leaves `ser_out` unchanged.
- R4: While the link clock is held low, `ser_out` keeps its value for any number of system cycles, at any bit position.
- R5: While the link clock is held high, `ser_out` likewise keeps its value, at any bit position.
- R6: `in_ready` is high for exactly one system cycle, and only on an active edge that falls after bit 0 of the current octet has gone out (or when no octet is loaded). At other times it stays low. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high.
- R7: If `in_valid` is low when a new octet is due, `ser_out` sends 1 for that bit and `underrun` goes to 1. The block keeps sending ones on each active edge until an octet is accepted. `underrun` returns to 0 on the edge that loads the next octet, and that octet starts with its bit 7.
- R8: After reset `ser_out` is 1, `underrun` is 0, `in_ready` is 0, and no octet is loaded. The first active edge therefore asks for a byte.
- R9: A level change on `link_clk` reaches `ser_out` through two synchroniser stages and one edge-detect stage. The edge-detect stage produces a strobe that is one system cycle long for each active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 1 | External, possibly gapped, serial bit clock |
| cfg_fall_edge | input | 1 | 0: rising edge is active, 1: falling edge is active |
| in_data | input | DATA_W | Octet offered for transmission |
| in_valid | input | 1 | `in_data` holds an octet to send |
| in_ready | output | 1 | Octet taken in this system cycle |
| ser_out | output | 1 | Serial data line |
| underrun | output | 1 | No octet was available when one was due |

## Verification
The hardest case to reach is a long stop of the link clock in the middle of an octet, held once at a low level and once at a high level. A related hard case is a switch of the active edge while the clock is stopped. The bench drives `link_clk` as an ordinary level from a task. It steps the serial stream bit by bit to the chosen position, then holds the level for tens of system cycles and compares `ser_out` on every cycle of the stop. It also moves the underrun/recovery point onto an octet boundary by lowering `in_valid` exactly between the last bit of one octet and the next active edge.

// File: rtl/gctx_pkg.sv
package gctx_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // pick the strobe of the configured direction
  function automatic logic pick_edge(input edge_sel_e sel, input logic rise, input logic fall);
    return (sel == EDGE_FALL) ? fall : rise;
  endfunction

endpackage

// File: rtl/gctx_sync.sv
module gctx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[LAST];
endmodule

// File: rtl/gctx_edge.sv
module gctx_edge
  import gctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic sel_fall,
  output logic adv
);
  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign adv  = pick_edge(edge_sel_e'(sel_fall), rise, fall);
endmodule

// File: rtl/gctx_shift.sv
module gctx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ser_out,
  output logic              underrun
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              need_byte;

  function automatic logic [DATA_W-1:0] shl1(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  assign need_byte = (left_q == '0);
  assign in_ready  = adv & need_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      left_q   <= '0;
      ser_out  <= 1'b1;
      underrun <= 1'b0;
    end else if (adv) begin
      if (need_byte) begin
        if (in_valid) begin
          ser_out  <= in_data[DATA_W-1];
          shreg_q  <= shl1(in_data);
          left_q   <= LAST_IDX;
          underrun <= 1'b0;
        end else begin
          ser_out  <= 1'b1;
          underrun <= 1'b1;
        end
      end else begin
        ser_out <= shreg_q[DATA_W-1];
        shreg_q <= shl1(shreg_q);
        left_q  <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/gapclk_ser_tx.sv
module gapclk_ser_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              cfg_fall_edge,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ser_out,
  output logic              underrun
);
  // internal events brought out by name for the checker
  logic link_lvl;
  logic adv_strobe;

  gctx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (link_clk),
    .sync_out (link_lvl)
  );

  gctx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (link_lvl),
    .sel_fall (cfg_fall_edge),
    .adv      (adv_strobe)
  );

  gctx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_strobe),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .ser_out  (ser_out),
    .underrun (underrun)
  );
endmodule

// File: rtl/gctx_chk.sv
module gctx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_fall_edge,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ser_out,
  input logic              underrun,
  input logic              link_lvl,
  input logic              adv_strobe
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |=> !adv_strobe); // R9

  AST_STROBE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |-> (link_lvl == !cfg_fall_edge)); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_strobe |=> $stable(ser_out)); // R4

  AST_READY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> adv_strobe); // R6

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R6

  AST_LOAD_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (ser_out == $past(in_data[DATA_W-1]))); // R1

  AST_UNDERRUN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ser_out); // R7

  AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !underrun); // R7
endmodule

bind gapclk_ser_tx gctx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_fall_edge (cfg_fall_edge),
  .in_data       (in_data),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .ser_out       (ser_out),
  .underrun      (underrun),
  .link_lvl      (link_lvl),
  .adv_strobe    (adv_strobe)
);

// File: tb/gapclk_ser_tx_test.sv
module gapclk_ser_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_clk = 1'b0;
  logic       cfg_fall_edge = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       ser_out;
  logic       underrun;

  int total = 0;
  int bad = 0;
  int rdy_seen = 0;
  bit done = 0;

  gapclk_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .cfg_fall_edge(cfg_fall_edge),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .ser_out(ser_out), .underrun(underrun)
  );

  always #4 clk = ~clk;

  // vector: {data, valid, expected serial octet}
  localparam logic [16:0] VEC [8] = '{
    {8'hA5, 1'b1, 8'hA5},
    {8'h3C, 1'b1, 8'h3C},
    {8'hFF, 1'b1, 8'hFF},
    {8'h00, 1'b1, 8'h00},
    {8'h00, 1'b0, 8'hFF},
    {8'h81, 1'b1, 8'h81},
    {8'h7E, 1'b1, 8'h7E},
    {8'h00, 1'b0, 8'hFF}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (in_ready) rdy_seen++;
    end
  endtask

  // one full link-clock period: high phase then low phase
  task automatic pulse();
    link_clk = 1'b1;
    hold(6);
    link_clk = 1'b0;
    hold(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] acc;
    int first_rdy;
    int later_rdy;
    logic keep;

    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 ser_out after reset", ser_out, 1);
    check("R8 underrun after reset", underrun, 0);
    check("R8 in_ready after reset", in_ready, 0);
    rst_n = 1'b1;
    hold(3);

    // table walk in rising-edge mode: R1 R2 R6 R7
    foreach (VEC[k]) begin
      in_data  = VEC[k][16:9];
      in_valid = VEC[k][8];
      acc = '0;
      first_rdy = 0;
      later_rdy = 0;
      for (int b = 0; b < 8; b++) begin
        rdy_seen = 0;
        pulse();
        if (b == 0) first_rdy = rdy_seen; else later_rdy += rdy_seen;
        acc = {acc[6:0], ser_out};
      end
      check($sformatf("R1 R2 octet entry %0d", k), acc, VEC[k][7:0]);
      check($sformatf("R7 underrun entry %0d", k), underrun, !VEC[k][8]);
      if (VEC[k][8]) begin
        check($sformatf("R6 ready on first bit entry %0d", k), first_rdy, 1);
        check($sformatf("R6 no ready mid-octet entry %0d", k), later_rdy, 0);
      end
    end

    // R3 falling-edge mode, switched while link clock is low
    cfg_fall_edge = 1'b1;
    in_data  = 8'h5A;
    in_valid = 1'b1;
    hold(4);
    check("R3 no move on mode switch", ser_out, 1);
    link_clk = 1'b1;
    hold(6);
    check("R3 rising edge ignored in falling mode", ser_out, 1);
    link_clk = 1'b0;
    hold(6);
    check("R3 falling edge moves data", ser_out, 0);
    acc = 8'h00;
    for (int b = 1; b < 8; b++) begin
      pulse();
      acc = {acc[6:0], ser_out};
    end
    check("R3 R1 octet in falling mode", acc, 8'h5A);

    // back to rising mode, stalls on byte A6 = 1,0,1,0,0,1,1,0
    cfg_fall_edge = 1'b0;
    in_data = 8'hA6;
    hold(4);
    pulse(); pulse(); pulse();
    check("R1 third bit of A6", ser_out, 1);
    keep = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (ser_out != 1'b1) keep = 1'b0;
    end
    check("R4 hold through low stall", keep, 1);
    pulse(); pulse();
    check("R1 fifth bit of A6", ser_out, 0);
    link_clk = 1'b1;
    hold(5);
    check("R3 rising edge moves data", ser_out, 1);
    keep = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (ser_out != 1'b1) keep = 1'b0;
    end
    check("R5 hold through high stall", keep, 1);
    link_clk = 1'b0;
    hold(6);
    check("R3 falling edge ignored in rising mode", ser_out, 1);
    pulse();
    check("R1 seventh bit of A6", ser_out, 1);
    in_valid = 1'b0;
    pulse();
    check("R1 last bit of A6", ser_out, 0);
    check("R7 no underrun before boundary", underrun, 0);

    // R7 underrun exactly on the boundary, then recovery
    pulse();
    check("R7 underrun sends one", ser_out, 1);
    check("R7 underrun flag set", underrun, 1);
    in_data  = 8'h00;
    in_valid = 1'b1;
    rdy_seen = 0;
    pulse();
    check("R7 recovery starts at bit 7", ser_out, 0);
    check("R7 underrun cleared on load", underrun, 0);
    check("R6 one ready on recovery", rdy_seen, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule